// File: doc/BRIEF.md
# Run-Time Configurable Set-Associative Data Cache

This block is a data cache placed between a processor that reads and writes 32-bit words and a memory that only moves whole blocks. Each line keeps a valid flag, a dirty flag, a recency rank and a tag. The tag is stored right-aligned for whatever geometry is active. Five inputs set the operating point while the block runs: the way count (1 to 5, including 3 and 5), the set count (2^0 to 2^4), the block size (2^2 to 2^5 bytes), the victim policy (least-recently-used or pseudo-random), and the write policy (write-back or write-through).

The processor raises a request with an address, a write flag and store data. It holds the request until a one-cycle ready pulse comes back, and the pulse carries a hit flag and the load data. Hits that do not have to reach memory finish in one cycle. A miss picks a victim line. Under write-back, a dirty victim is first copied to memory as a whole block. The line is then refilled with one block read. A store miss allocates the line and merges the store word into the refilled block. A flush request copies every dirty line to memory and then invalidates the whole array. The memory side uses a request line that stays high until an acknowledge arrives, with one full-width beat per block.

Top module: `sa_cache_ctrl`

## Requirements
- R1: After reset or a completed flush no line is valid. The first access to any address misses, and cpu_ready and mem_req are low after reset.
- R2: A load that hits returns the stored word with cpu_hit high and makes no memory transfer.
- R3: A miss reads exactly one block from memory at the block-aligned address. Afterwards every word of that block hits.
- R4: On a miss, an invalid way among the active ways is filled before any valid way is evicted. With N ways, N distinct tags in one set all stay resident.
- R5: In least-recently-used mode, a miss in a full set evicts the way whose last hit or fill is oldest.
- R6: In random mode, a miss in a full set replaces exactly one resident line, chosen from the active ways by an 8-bit LFSR reduced modulo the way count.
- R7: Under write-back, a store hit sets the dirty flag and makes no memory transfer. Evicting a dirty line writes its whole block to its own address before the refill read.
- R8: Under write-through, every store sends the whole updated block to memory. A store miss does this after the refill. No line is ever dirty, and eviction never writes.
- R9: A store miss allocates the line, merges the store word into the refilled block, and a later load of that word hits with the stored value.
- R10: A flush writes every dirty line to memory as a block, makes no other transfer, and leaves the cache with no valid line.
- R11: The stored tag of every valid line has zero in every bit above the tag width of the active geometry.
- R12: Within each set, the recency ranks of the active ways are always distinct and cover 0 to ways-1.
- R13: cpu_ready is a single-cycle pulse that only follows a held request. mem_req stays high until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ways | input | 3 | Active way count, 1 to 5 |
| cfg_set_bits | input | 3 | log2 of the set count, 0 to 4 |
| cfg_blk_bits | input | 3 | log2 of the block size in bytes, 2 to 5 |
| cfg_random | input | 1 | 1 selects random victims, 0 selects least-recently-used |
| cfg_wthru | input | 1 | 1 selects write-through, 0 selects write-back |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for a store |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store word |
| cpu_flush | input | 1 | Flush request, held until cpu_ready, has priority over cpu_req |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Hit flag, valid with cpu_ready |
| cpu_rdata | output | 32 | Load word, valid with cpu_ready |
| mem_req | output | 1 | Block transfer request, held until mem_ack |
| mem_we | output | 1 | 1 for a block write, 0 for a block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 256 | Block write data, word 0 in the low bits |
| mem_rdata | input | 256 | Block read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The bench builds the block with its default maximum geometry of 5 ways, 16 sets and 32-byte blocks, and drives four run-time operating points. The first is three ways with four sets of 16-byte blocks, which covers non-power-of-two recency order. The second is a single 4-byte line under write-back, which places a dirty eviction in front of a refill. The third is two ways with two sets of 32-byte blocks under write-through, which checks full-block store traffic. The last is five ways in one set with random victims, where exactly one dirty write-back exposes the random pick and a following flush has several dirty lines to drain.

// File: rtl/sac_pkg.sv
package sac_pkg;
    localparam int ADDR_W       = 32;
    localparam int WORD_W       = 32;
    localparam int CFG_W        = 3;
    localparam int MAX_WAYS     = 5;
    localparam int MAX_SET_BITS = 4;
    localparam int MAX_BLK_BITS = 5;
    localparam int MAX_SETS     = 1 << MAX_SET_BITS;
    localparam int BLK_W        = 8 << MAX_BLK_BITS;
    localparam int BLK_WORDS    = BLK_W / WORD_W;
    localparam int WAY_W        = $clog2(MAX_WAYS);
    localparam int AGE_W        = WAY_W;
    localparam int SET_W        = MAX_SET_BITS;
    localparam int WOFF_W       = MAX_BLK_BITS - 2;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [AGE_W-1:0]  age;
        logic [ADDR_W-1:0] tag;
    } line_t;

    typedef enum logic [2:0] {
        S_IDLE, S_WBACK, S_FILL, S_WTHRU, S_FLSCAN, S_FLWB
    } state_t;

    function automatic logic [ADDR_W-1:0] low_mask(input int n);
        return (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] tag,
                                                     input logic [SET_W-1:0]  idx,
                                                     input logic [CFG_W-1:0]  sb,
                                                     input logic [CFG_W-1:0]  bb);
        return (tag << (int'(sb) + int'(bb))) | (ADDR_W'(idx) << bb);
    endfunction

    function automatic logic [BLK_W-1:0] blk_mask(input logic [CFG_W-1:0] bb);
        logic [BLK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BLK_WORDS; i++)
            if (i < (1 << (int'(bb) - 2))) m[i*WORD_W +: WORD_W] = '1;
        return m;
    endfunction
endpackage

// File: rtl/sac_addr_split.sv
module sac_addr_split
    import sac_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  set_bits,
    input  logic [CFG_W-1:0]  blk_bits,
    output logic [ADDR_W-1:0] tag,
    output logic [SET_W-1:0]  idx,
    output logic [WOFF_W-1:0] woff,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] idx_full, woff_full;

    always_comb begin
        tag       = addr >> (int'(blk_bits) + int'(set_bits));
        idx_full  = (addr >> blk_bits) & low_mask(int'(set_bits));
        woff_full = (addr >> 2) & low_mask(int'(blk_bits) - 2);
        idx       = idx_full[SET_W-1:0];
        woff      = woff_full[WOFF_W-1:0];
        base      = addr & ~low_mask(int'(blk_bits));
    end
endmodule

// File: rtl/sac_victim_sel.sv
module sac_victim_sel
    import sac_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [MAX_WAYS-1:0]             valid,
    input  logic [MAX_WAYS-1:0][AGE_W-1:0]  age,
    input  logic [CFG_W-1:0]                ways,
    input  logic                            use_random,
    output logic [WAY_W-1:0]                victim
);
    localparam int LFSR_W = 8;
    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] pick;
    logic              found;

    always_ff @(posedge clk) begin
        if (rst) lfsr <= LFSR_W'(1);
        else     lfsr <= {lfsr[LFSR_W-2:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    always_comb begin
        found  = 1'b0;
        victim = '0;
        pick   = (ways == '0) ? '0 : lfsr % LFSR_W'(ways);
        for (int w = 0; w < MAX_WAYS; w++) begin
            if (!found && w < int'(ways) && !valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            if (use_random) begin
                victim = pick[WAY_W-1:0];
            end else begin
                for (int w = 0; w < MAX_WAYS; w++)
                    if (w < int'(ways) && age[w] == AGE_W'(int'(ways) - 1))
                        victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/sa_cache_ctrl.sv
module sa_cache_ctrl
    import sac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_ways,
    input  logic [CFG_W-1:0]  cfg_set_bits,
    input  logic [CFG_W-1:0]  cfg_blk_bits,
    input  logic              cfg_random,
    input  logic              cfg_wthru,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              cpu_flush,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata,
    input  logic              mem_ack
);
    state_t            state;
    line_t             lines [MAX_SETS][MAX_WAYS];
    logic [BLK_W-1:0]  data  [MAX_SETS][MAX_WAYS];

    logic [ADDR_W-1:0] a_tag, a_base;
    logic [SET_W-1:0]  a_idx;
    logic [WOFF_W-1:0] a_woff;

    logic                           r_we;
    logic [WORD_W-1:0]              r_wdata;
    logic [ADDR_W-1:0]              r_tag, r_base;
    logic [SET_W-1:0]               r_idx, f_set;
    logic [WOFF_W-1:0]              r_woff;
    logic [WAY_W-1:0]               r_way, f_way, hit_way, victim;

    logic [MAX_WAYS-1:0]            hit_vec, set_valid;
    logic [MAX_WAYS-1:0][AGE_W-1:0] set_age, t_age;
    logic                           hit, take, touch_en, flush_step, flush_last;
    logic [SET_W-1:0]               t_set;
    logic [WAY_W-1:0]               t_way;
    logic                           d_en;
    logic [SET_W-1:0]               d_set;
    logic [WAY_W-1:0]               d_way;
    logic [BLK_W-1:0]               d_val;

    sac_addr_split u_split (
        .addr(cpu_addr), .set_bits(cfg_set_bits), .blk_bits(cfg_blk_bits),
        .tag(a_tag), .idx(a_idx), .woff(a_woff), .base(a_base)
    );

    sac_victim_sel u_victim (
        .clk(clk), .rst(rst), .valid(set_valid), .age(set_age),
        .ways(cfg_ways), .use_random(cfg_random), .victim(victim)
    );

    // lookup in the set addressed by the incoming request
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < MAX_WAYS; w++) begin
            set_valid[w] = lines[a_idx][w].valid;
            set_age[w]   = lines[a_idx][w].age;
            hit_vec[w]   = (w < int'(cfg_ways)) && lines[a_idx][w].valid
                           && (lines[a_idx][w].tag == a_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit  = |hit_vec;
        take = (state == S_IDLE) && !cpu_ready && !cpu_flush && cpu_req;
    end

    // recency update: the touched way goes to rank 0, younger ways age by one
    always_comb begin
        touch_en = (take && hit) || (state == S_FILL && mem_ack);
        t_set    = (state == S_FILL) ? r_idx : a_idx;
        t_way    = (state == S_FILL) ? r_way : hit_way;
        for (int w = 0; w < MAX_WAYS; w++) begin
            t_age[w] = lines[t_set][w].age;
            if (WAY_W'(w) == t_way)
                t_age[w] = '0;
            else if (w < int'(cfg_ways) && lines[t_set][w].age < lines[t_set][t_way].age)
                t_age[w] = lines[t_set][w].age + AGE_W'(1);
        end
    end

    // block data write port: store hit merge or refill merge
    always_comb begin
        d_en  = 1'b0;
        d_set = a_idx;
        d_way = hit_way;
        d_val = data[a_idx][hit_way];
        if (take && hit && cpu_we) begin
            d_en = 1'b1;
            d_val[a_woff*WORD_W +: WORD_W] = cpu_wdata;
        end else if (state == S_FILL && mem_ack) begin
            d_en  = 1'b1;
            d_set = r_idx;
            d_way = r_way;
            d_val = mem_rdata & blk_mask(cfg_blk_bits);
            if (r_we) d_val[r_woff*WORD_W +: WORD_W] = r_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (d_en) data[d_set][d_way] <= d_val;
    end

    always_comb begin
        flush_step = (state == S_FLSCAN && !(lines[f_set][f_way].valid && lines[f_set][f_way].dirty))
                   || (state == S_FLWB && mem_ack);
        flush_last = (int'(f_set) == MAX_SETS - 1) && (int'(f_way) == MAX_WAYS - 1);
    end

    // memory side
    always_comb begin
        mem_req   = (state == S_WBACK) || (state == S_FILL) || (state == S_WTHRU) || (state == S_FLWB);
        mem_we    = (state != S_FILL);
        mem_addr  = r_base;
        mem_wdata = data[r_idx][r_way];
        if (state == S_WBACK)
            mem_addr = line_base(lines[r_idx][r_way].tag, r_idx, cfg_set_bits, cfg_blk_bits);
        else if (state == S_FLWB) begin
            mem_addr  = line_base(lines[f_set][f_way].tag, f_set, cfg_set_bits, cfg_blk_bits);
            mem_wdata = data[f_set][f_way];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cpu_ready <= 1'b0;
            cpu_hit   <= 1'b0;
            cpu_rdata <= '0;
            r_we      <= 1'b0;
            r_wdata   <= '0;
            r_tag     <= '0;
            r_base    <= '0;
            r_idx     <= '0;
            r_woff    <= '0;
            r_way     <= '0;
            f_set     <= '0;
            f_way     <= '0;
            for (int s = 0; s < MAX_SETS; s++)
                for (int w = 0; w < MAX_WAYS; w++)
                    lines[s][w] <= '{valid: 1'b0, dirty: 1'b0, age: AGE_W'(w), tag: '0};
        end else begin
            cpu_ready <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (!cpu_ready && cpu_flush) begin
                        state <= S_FLSCAN;
                        f_set <= '0;
                        f_way <= '0;
                    end else if (take) begin
                        r_we    <= cpu_we;
                        r_wdata <= cpu_wdata;
                        r_tag   <= a_tag;
                        r_idx   <= a_idx;
                        r_woff  <= a_woff;
                        r_base  <= a_base;
                        cpu_hit <= hit;
                        if (hit) begin
                            r_way <= hit_way;
                            if (!cpu_we) begin
                                cpu_rdata <= data[a_idx][hit_way][a_woff*WORD_W +: WORD_W];
                                cpu_ready <= 1'b1;
                            end else if (cfg_wthru) begin
                                state <= S_WTHRU;
                            end else begin
                                lines[a_idx][hit_way].dirty <= 1'b1;
                                cpu_ready <= 1'b1;
                            end
                        end else begin
                            r_way <= victim;
                            if (lines[a_idx][victim].valid && lines[a_idx][victim].dirty)
                                state <= S_WBACK;
                            else
                                state <= S_FILL;
                        end
                    end
                end
                S_WBACK: if (mem_ack) begin
                    lines[r_idx][r_way].dirty <= 1'b0;
                    state <= S_FILL;
                end
                S_FILL: if (mem_ack) begin
                    lines[r_idx][r_way].valid <= 1'b1;
                    lines[r_idx][r_way].tag   <= r_tag;
                    lines[r_idx][r_way].dirty <= r_we && !cfg_wthru;
                    cpu_rdata <= mem_rdata[r_woff*WORD_W +: WORD_W];
                    if (r_we && cfg_wthru) begin
                        state <= S_WTHRU;
                    end else begin
                        state     <= S_IDLE;
                        cpu_ready <= 1'b1;
                    end
                end
                S_WTHRU: if (mem_ack) begin
                    state     <= S_IDLE;
                    cpu_ready <= 1'b1;
                end
                S_FLSCAN: if (lines[f_set][f_way].valid && lines[f_set][f_way].dirty) state <= S_FLWB;
                S_FLWB:   if (mem_ack) lines[f_set][f_way].dirty <= 1'b0;
                default:  state <= S_IDLE;
            endcase

            if (touch_en)
                for (int w = 0; w < MAX_WAYS; w++) lines[t_set][w].age <= t_age[w];

            if (flush_step) begin
                if (flush_last) begin
                    for (int s = 0; s < MAX_SETS; s++)
                        for (int w = 0; w < MAX_WAYS; w++)
                            lines[s][w] <= '{valid: 1'b0, dirty: 1'b0, age: AGE_W'(w), tag: '0};
                    state     <= S_IDLE;
                    cpu_ready <= 1'b1;
                    cpu_hit   <= 1'b0;
                end else begin
                    state <= S_FLSCAN;
                    if (int'(f_way) == MAX_WAYS - 1) begin
                        f_way <= '0;
                        f_set <= f_set + SET_W'(1);
                    end else begin
                        f_way <= f_way + WAY_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sac_chk.sv
module sac_chk
    import sac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_flush,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [CFG_W-1:0] cfg_ways,
    input logic [CFG_W-1:0] cfg_set_bits,
    input logic [CFG_W-1:0] cfg_blk_bits,
    input logic             cfg_wthru,
    input line_t            lines [MAX_SETS][MAX_WAYS]
);
    assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready) else $error("R13 ready longer than one cycle");

    assert_ready_cause_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_ready) |-> $past(cpu_req || cpu_flush)) else $error("R13 ready without request");

    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req) else $error("R13 memory request dropped");

    always @(posedge clk) begin
        if (!rst) begin
            for (int s = 0; s < MAX_SETS; s++) begin
                logic [(1 << AGE_W)-1:0] seen;
                seen = '0;
                for (int w = 0; w < MAX_WAYS; w++) begin
                    if (w < int'(cfg_ways)) seen[lines[s][w].age] = 1'b1;
                    if (lines[s][w].valid)
                        assert_tag_align_R11: assert ((lines[s][w].tag >>
                            (ADDR_W - int'(cfg_blk_bits) - int'(cfg_set_bits))) == '0)
                            else $error("R11 tag not right aligned");
                    if (cfg_wthru)
                        assert_wt_clean_R8: assert (!lines[s][w].dirty)
                            else $error("R8 dirty line under write-through");
                end
                assert_lru_unique_R12: assert ($countones(seen) == int'(cfg_ways))
                    else $error("R12 recency ranks collide");
            end
        end
    end
endmodule

bind sa_cache_ctrl sac_chk u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_flush(cpu_flush),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_ack(mem_ack),
    .cfg_ways(cfg_ways), .cfg_set_bits(cfg_set_bits), .cfg_blk_bits(cfg_blk_bits),
    .cfg_wthru(cfg_wthru), .lines(lines)
);

// File: tb/sa_cache_ctrl_tb.sv
module sa_cache_ctrl_tb;
    import sac_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CFG_W-1:0]  cfg_ways = 3'd3, cfg_set_bits = 3'd2, cfg_blk_bits = 3'd4;
    logic              cfg_random = 1'b0, cfg_wthru = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0, cpu_flush = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [WORD_W-1:0] cpu_wdata = '0;
    logic              cpu_ready, cpu_hit, mem_req, mem_we;
    logic [WORD_W-1:0] cpu_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [BLK_W-1:0]  mem_wdata;
    logic [BLK_W-1:0]  mem_rdata = '0;
    logic              mem_ack = 1'b0;

    int n_chk = 0, n_fail = 0, n_ops = 0, cycles = 0;
    logic              op_we   [8];
    logic [ADDR_W-1:0] op_addr [8];
    logic [WORD_W-1:0] op_data [8];
    logic [WORD_W-1:0] mem [1024];

    always #10 clk = ~clk;

    sa_cache_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_ways(cfg_ways), .cfg_set_bits(cfg_set_bits),
        .cfg_blk_bits(cfg_blk_bits), .cfg_random(cfg_random), .cfg_wthru(cfg_wthru),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_flush(cpu_flush), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [WORD_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return 32'hA000_0000 | a;
    endfunction

    // block memory model, answers one negedge after it sees a request
    always @(negedge clk) begin
        if (rst) mem_ack = 1'b0;
        else if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (n_ops < 8) begin
                op_we[n_ops] = mem_we; op_addr[n_ops] = mem_addr; op_data[n_ops] = mem_wdata[31:0];
            end
            n_ops++;
            mem_rdata = '0;
            for (int i = 0; i < (1 << (int'(cfg_blk_bits) - 2)); i++) begin
                if (mem_we) mem[((mem_addr >> 2) + ADDR_W'(i)) & 1023] = mem_wdata[i*32 +: 32];
                else        mem_rdata[i*32 +: 32] = mem[((mem_addr >> 2) + ADDR_W'(i)) & 1023];
            end
            mem_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL R13 watchdog actual=%0d expected=<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wait_ready();
        int k;
        k = 0;
        while (!cpu_ready && k < 500) begin @(negedge clk); k++; end
        if (k >= 500) chk("R13 ready timeout", 32'd0, 32'd1);
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic hit, output logic [31:0] rd);
        n_ops = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        wait_ready();
        hit = cpu_hit; rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        chk("R13 ready single pulse", 32'(cpu_ready), 32'd0);
    endtask

    task automatic flush();
        n_ops = 0;
        @(negedge clk);
        cpu_flush = 1'b1;
        @(negedge clk);
        wait_ready();
        cpu_flush = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input int w, input int sb, input int bb, input logic rnd, input logic wt);
        cfg_ways = CFG_W'(w); cfg_set_bits = CFG_W'(sb); cfg_blk_bits = CFG_W'(bb);
        cfg_random = rnd; cfg_wthru = wt;
    endtask

    task automatic t_reset();
        logic h; logic [31:0] d;
        chk("R1 ready low after reset", 32'(cpu_ready), 32'd0);
        chk("R1 mem_req low after reset", 32'(mem_req), 32'd0);
        access(1'b0, 32'h100, 0, h, d);
        chk("R1 first access misses", 32'(h), 32'd0);
        chk("R3 one block read", n_ops, 1);
        chk("R3 read is block read", 32'(op_we[0]), 32'd0);
        chk("R3 block aligned address", op_addr[0], 32'h100);
        chk("R3 miss data", d, pat(32'h100));
    endtask

    task automatic t_read_hit();
        logic h; logic [31:0] d;
        for (int i = 1; i < 4; i++) begin
            access(1'b0, 32'h100 + 32'(4*i), 0, h, d);
            chk("R2 R3 hit inside refilled block", 32'(h), 32'd1);
            chk("R2 no memory transfer on hit", n_ops, 0);
            chk("R2 hit data", d, pat(32'h100 + 32'(4*i)));
        end
    endtask

    task automatic t_fill_ways();
        logic h; logic [31:0] d;
        access(1'b0, 32'h140, 0, h, d);
        chk("R4 second tag misses without write", n_ops, 1);
        access(1'b0, 32'h180, 0, h, d);
        chk("R4 third tag misses without write", n_ops, 1);
        access(1'b0, 32'h100, 0, h, d); chk("R4 tag A resident", 32'(h), 32'd1);
        access(1'b0, 32'h140, 0, h, d); chk("R4 tag B resident", 32'(h), 32'd1);
        access(1'b0, 32'h180, 0, h, d); chk("R4 tag C resident", 32'(h), 32'd1);
        chk("R4 data of third way", d, pat(32'h180));
    endtask

    task automatic t_lru();
        logic h; logic [31:0] d;
        access(1'b0, 32'h100, 0, h, d);
        access(1'b0, 32'h180, 0, h, d);
        access(1'b0, 32'h1C0, 0, h, d);
        chk("R5 new tag misses", 32'(h), 32'd0);
        access(1'b0, 32'h100, 0, h, d); chk("R5 recent line kept", 32'(h), 32'd1);
        access(1'b0, 32'h180, 0, h, d); chk("R5 recent line kept", 32'(h), 32'd1);
        access(1'b0, 32'h1C0, 0, h, d); chk("R5 new line resident", 32'(h), 32'd1);
        access(1'b0, 32'h140, 0, h, d); chk("R5 R12 oldest line evicted", 32'(h), 32'd0);
        access(1'b0, 32'h100, 0, h, d); chk("R5 R12 next oldest evicted", 32'(h), 32'd0);
    endtask

    task automatic t_wb();
        logic h; logic [31:0] d;
        flush();
        chk("R10 clean flush writes nothing", n_ops, 0);
        set_cfg(1, 0, 2, 1'b0, 1'b0);
        access(1'b1, 32'h200, 32'h1111_1111, h, d);
        chk("R9 store miss reports miss", 32'(h), 32'd0);
        chk("R9 store miss allocates with one read", n_ops, 1);
        chk("R9 allocate is a read", 32'(op_we[0]), 32'd0);
        access(1'b0, 32'h200, 0, h, d);
        chk("R9 R11 load after store miss hits", 32'(h), 32'd1);
        chk("R9 merged store data", d, 32'h1111_1111);
        access(1'b1, 32'h200, 32'h2222_2222, h, d);
        chk("R7 store hit", 32'(h), 32'd1);
        chk("R7 store hit makes no transfer", n_ops, 0);
        chk("R7 memory untouched by store hit", mem[32'h200 >> 2], pat(32'h200));
        access(1'b0, 32'h300, 0, h, d);
        chk("R7 dirty eviction transfer count", n_ops, 2);
        chk("R7 write-back first", 32'(op_we[0]), 32'd1);
        chk("R7 write-back address", op_addr[0], 32'h200);
        chk("R7 write-back data", op_data[0], 32'h2222_2222);
        chk("R7 refill after write-back", 32'(op_we[1]), 32'd0);
        chk("R7 refill address", op_addr[1], 32'h300);
        chk("R7 refill data", d, pat(32'h300));
    endtask

    task automatic t_wt();
        logic h; logic [31:0] d;
        flush();
        chk("R10 flush of clean line writes nothing", n_ops, 0);
        set_cfg(2, 1, 5, 1'b0, 1'b1);
        access(1'b1, 32'h404, 32'h3333_3333, h, d);
        chk("R8 store miss transfers", n_ops, 2);
        chk("R8 refill first", 32'(op_we[0]), 32'd0);
        chk("R8 block write second", 32'(op_we[1]), 32'd1);
        chk("R8 block write address", op_addr[1], 32'h400);
        chk("R8 stored word in memory", mem[32'h404 >> 2], 32'h3333_3333);
        chk("R8 whole block word 0", mem[32'h400 >> 2], pat(32'h400));
        chk("R8 whole block last word", mem[32'h41C >> 2], pat(32'h41C));
        access(1'b1, 32'h418, 32'h4444_4444, h, d);
        chk("R8 store hit", 32'(h), 32'd1);
        chk("R8 store hit writes block", n_ops, 1);
        chk("R8 store hit block address", op_addr[0], 32'h400);
        chk("R8 new word in memory", mem[32'h418 >> 2], 32'h4444_4444);
        chk("R8 earlier word kept", mem[32'h404 >> 2], 32'h3333_3333);
        access(1'b0, 32'h440, 0, h, d);
        access(1'b0, 32'h480, 0, h, d);
        chk("R8 eviction never writes", n_ops, 1);
        chk("R8 eviction is a read", 32'(op_we[0]), 32'd0);
    endtask

    task automatic t_rand();
        logic h; logic [31:0] d;
        logic [31:0] k;
        flush();
        set_cfg(5, 0, 2, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            access(1'b1, 32'h600 + 32'(4*i), 32'h5000_0000 + 32'(i), h, d);
            chk("R4 five ways fill invalid first", n_ops, 1);
        end
        access(1'b0, 32'h614, 0, h, d);
        chk("R6 one victim written back", n_ops, 2);
        chk("R6 victim write first", 32'(op_we[0]), 32'd1);
        chk("R6 victim inside the set", 32'(op_addr[0] >= 32'h600 && op_addr[0] <= 32'h610), 32'd1);
        k = (op_addr[0] - 32'h600) >> 2;
        chk("R6 R11 victim data matches its tag", op_data[0], 32'h5000_0000 + k);
        chk("R6 refill after victim", op_addr[1], 32'h614);
    endtask

    task automatic t_flush();
        logic h; logic [31:0] d;
        int wr;
        flush();
        wr = 0;
        for (int i = 0; i < 8; i++) if (i < n_ops && op_we[i]) wr++;
        chk("R10 flush writes every dirty line", n_ops, 4);
        chk("R10 flush transfers are writes", wr, 4);
        access(1'b0, 32'h614, 0, h, d);
        chk("R10 clean line gone after flush", 32'(h), 32'd0);
        access(1'b0, 32'h608, 0, h, d);
        chk("R10 dirty line gone after flush", 32'(h), 32'd0);
        chk("R10 flushed data reached memory", d, 32'h5000_0002);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_hit();
        t_fill_ways();
        t_lru();
        t_wb();
        t_wt();
        t_rand();
        t_flush();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule